// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Front End

This block is the digital front end of an 8-bit voltage-output converter. A host writes a byte over a parallel port that has an active-low select and an active-low write strobe. The byte lands in an input register. A second register, the code register, holds the value that drives the converter. Three more active-low controls act on the pair. The load control moves data across, the clear control zeroes the output, and the power-down control sets the low-power state. The converter output is 2·Vref·N/256 for a straight-binary code N from 0 to 255.

The update mode is chosen separately for every write. The load control is sampled when the write ends. If load is low, the code register takes the new byte at once (automatic update). If load is high, the new byte stays pending until load next falls (synchronous update). After reset the input register is zero and the code register follows it, so the output stays at zero until the first write. All strobes are asynchronous to the block. They pass through two-flop synchronizers on a system clock that runs at least four times faster than the shortest strobe. A one-cycle update strobe marks every change of the code register.

Top module: `dual_latch_dac_if`

## Requirements
- R1: A write is in progress only while `cs_ni` and `wr_ni` are both low. The byte stored is the value `data_i` held in the last clock in which both were low, whichever strobe rises first, even if `data_i` changes as the write ends.
- R2: If `ld_ni` is low when a write ends, the code register takes the written byte (automatic update).
- R3: If `ld_ni` is high when a write ends, `code_o` keeps its old value. On the next falling edge of `ld_ni` the code register takes the input register contents. When several writes come before that falling edge, the last one wins.
- R4: While `clr_ni` is low, `code_o` is 0 with no clock delay, and the code register is zeroed. Clear wins over a load falling edge that is synchronized in the same clock.
- R5: After reset, `code_o` is 0 and the input register is 0. The code register follows the input register until the first write ends. A first write with `ld_ni` high leaves `code_o` at 0.
- R6: While `pd_ni` is low, `pwrdn_o` is 1 and `out_en_o` is 0, with two clocks of synchronizer delay. Both registers keep their contents and can still be written in that state. After reset `pwrdn_o` is 0 and `out_en_o` is 1.
- R7: `upd_o` is high for exactly one clock each time the code register changes value. It stays low when an update carries the value the register already holds.
- R8: For an automatic update, `code_o` changes at the third rising clock edge after the strobe that ends the write rises: two synchronizer edges and one register edge.
- R9: A pulse on `wr_ni` while `cs_ni` is high changes neither register. It has no effect even if `ld_ni` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous active-low reset (power-on) |
| cs_ni | input | 1 | Active-low chip select |
| wr_ni | input | 1 | Active-low write strobe |
| ld_ni | input | 1 | Active-low load control |
| clr_ni | input | 1 | Active-low asynchronous clear |
| pd_ni | input | 1 | Active-low power-down request |
| data_i | input | CODE_W | Parallel data bus |
| code_o | output | CODE_W | Straight-binary converter code |
| pwrdn_o | output | 1 | Power-down flag |
| out_en_o | output | 1 | Converter output enable |
| upd_o | output | 1 | One-clock pulse on each code register change |

## Verification
Automatic writes are driven with the patterns 0x11, 0xFF, 0x00, 0x80 and 0xC3. These catch stuck or swapped data bits, and they catch a write that is dropped because its value equals zero. One write ends with select rising first and data changing in the same cycle, which separates correct end-of-write capture from late sampling of the bus. Two synchronous writes are followed by one load falling edge, which shows that the last write wins. A strobe with select high, followed by a load edge, shows that the input register was left untouched. A clear that lands together with a load edge, and a repeated write of the same value, confirm the clear priority and the change-only update strobe.

// File: rtl/dacif_pkg.sv
package dacif_pkg;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic ld_n;
    logic clr_n;
    logic pd_n;
  } strobe_t;

  localparam int unsigned STROBE_W = $bits(strobe_t);
  localparam strobe_t STROBE_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, ld_n: 1'b1,
                                      clr_n: 1'b1, pd_n: 1'b1};

endpackage

// File: rtl/dacif_sync.sv
module dacif_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/dacif_event.sv
module dacif_event
  import dacif_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  strobe_t syn_i,
  output logic    wr_act_o,
  output logic    wr_end_o,
  output logic    auto_o,
  output logic    ld_fall_o,
  output logic    clr_act_o,
  output logic    pd_act_o
);

  logic act_prev_q, ld_prev_q;

  assign wr_act_o = ~syn_i.cs_n & ~syn_i.wr_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_prev_q <= 1'b0;
      ld_prev_q  <= 1'b1;
    end else begin
      act_prev_q <= wr_act_o;
      ld_prev_q  <= syn_i.ld_n;
    end
  end

  // first of the two strobes to rise ends the write
  assign wr_end_o  = act_prev_q & ~wr_act_o;
  assign auto_o    = ~syn_i.ld_n;
  assign ld_fall_o = ld_prev_q & ~syn_i.ld_n;
  assign clr_act_o = ~syn_i.clr_n;
  assign pd_act_o  = ~syn_i.pd_n;

endmodule

// File: rtl/dacif_regs.sv
module dacif_regs #(
  parameter int unsigned CODE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] wdata_i,
  input  logic              wr_end_i,
  input  logic              auto_i,
  input  logic              ld_fall_i,
  input  logic              clr_i,
  output logic [CODE_W-1:0] code_q_o,
  output logic              por_o,
  output logic              upd_o
);

  logic [CODE_W-1:0] in_q, in_d, code_q, code_d;
  logic              por_q, por_d, upd_q;

  always_comb begin
    in_d  = wr_end_i ? wdata_i : in_q;
    por_d = por_q & ~wr_end_i;
    if (clr_i)                  code_d = '0;
    else if (wr_end_i && auto_i) code_d = wdata_i;
    else if (ld_fall_i)         code_d = in_q;
    else if (por_q && !wr_end_i) code_d = in_q;  // transparent until first write
    else                        code_d = code_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q   <= '0;
      code_q <= '0;
      por_q  <= 1'b1;
      upd_q  <= 1'b0;
    end else begin
      in_q   <= in_d;
      code_q <= code_d;
      por_q  <= por_d;
      upd_q  <= (code_d != code_q);
    end
  end

  assign code_q_o = code_q;
  assign por_o    = por_q;
  assign upd_o    = upd_q;

endmodule

// File: rtl/dual_latch_dac_if.sv
module dual_latch_dac_if
  import dacif_pkg::*;
#(
  parameter int unsigned CODE_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              wr_ni,
  input  logic              ld_ni,
  input  logic              clr_ni,
  input  logic              pd_ni,
  input  logic [CODE_W-1:0] data_i,
  output logic [CODE_W-1:0] code_o,
  output logic              pwrdn_o,
  output logic              out_en_o,
  output logic              upd_o
);

  strobe_t           raw_s, syn_s;
  logic [STROBE_W-1:0] syn_v;
  logic [CODE_W-1:0] data_syn, data_hold_q, code_q;
  logic wr_act, wr_end, auto_upd, ld_fall, clr_act, pd_act, por_q;

  assign raw_s = '{cs_n: cs_ni, wr_n: wr_ni, ld_n: ld_ni, clr_n: clr_ni, pd_n: pd_ni};

  dacif_sync #(.W(STROBE_W), .STAGES(SYNC_STAGES), .RST_VAL(STROBE_IDLE)) i_sync_ctrl (
    .clk_i, .rst_ni, .d_i(raw_s), .q_o(syn_v)
  );
  assign syn_s = strobe_t'(syn_v);

  // data delayed by the same depth so it lines up with the strobes
  dacif_sync #(.W(CODE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_sync_data (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_syn)
  );

  dacif_event i_event (
    .clk_i, .rst_ni, .syn_i(syn_s),
    .wr_act_o(wr_act), .wr_end_o(wr_end), .auto_o(auto_upd),
    .ld_fall_o(ld_fall), .clr_act_o(clr_act), .pd_act_o(pd_act)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     data_hold_q <= '0;
    else if (wr_act) data_hold_q <= data_syn;
  end

  dacif_regs #(.CODE_W(CODE_W)) i_regs (
    .clk_i, .rst_ni, .wdata_i(data_hold_q), .wr_end_i(wr_end), .auto_i(auto_upd),
    .ld_fall_i(ld_fall), .clr_i(clr_act), .code_q_o(code_q), .por_o(por_q), .upd_o
  );

  assign code_o   = clr_ni ? code_q : '0;
  assign pwrdn_o  = pd_act;
  assign out_en_o = ~pd_act;

endmodule

// File: rtl/dacif_chk.sv
module dacif_chk #(
  parameter int unsigned CODE_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_ni,
  input logic              ld_ni,
  input logic              clr_ni,
  input logic              pd_ni,
  input logic [CODE_W-1:0] code_o,
  input logic              pwrdn_o,
  input logic              upd_o,
  input logic [CODE_W-1:0] code_q,
  input logic              por_q
);

  assert_clear_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> code_o == '0);

  assert_pd_flag_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pd_ni && !$past(pd_ni) && !$past(pd_ni, 2)) |-> pwrdn_o);

  assert_upd_change_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> code_q != $past(code_q));

  assert_por_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_q |-> code_q == '0);

  assert_hold_quiet_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni && $past(cs_ni) && $past(cs_ni, 2) && $past(cs_ni, 3) &&
     ld_ni && $past(ld_ni) && $past(ld_ni, 2) && $past(ld_ni, 3) &&
     clr_ni && $past(clr_ni) && $past(clr_ni, 2)) |=> $stable(code_q));

endmodule

bind dual_latch_dac_if dacif_chk #(.CODE_W(CODE_W)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_ni(cs_ni), .ld_ni(ld_ni), .clr_ni(clr_ni),
  .pd_ni(pd_ni), .code_o(code_o), .pwrdn_o(pwrdn_o), .upd_o(upd_o),
  .code_q(code_q), .por_q(por_q)
);

// File: tb/test_dual_latch_dac_if.sv
module test_dual_latch_dac_if;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
  logic [7:0] data = 8'h00, code;
  logic pwrdn, out_en, upd;
  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  logic [7:0] in_m = 8'h00, code_m = 8'h00;

  always #5 clk = ~clk;

  dual_latch_dac_if i_dual_latch_dac_if (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .ld_ni(ld_n),
    .clr_ni(clr_n), .pd_ni(pd_n), .data_i(data), .code_o(code),
    .pwrdn_o(pwrdn), .out_en_o(out_en), .upd_o(upd)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_code(input logic [7:0] v);
    if (v != code_m) exp_q.push_back(v);
    code_m = v;
  endtask

  // scoreboard monitor for R7
  always @(negedge clk) begin
    if (rst_n && upd) begin
      if (exp_q.size() == 0) check("R7 unexpected update", code, 8'hxx);
      else check("R7 update value", code, exp_q.pop_front());
    end
  end

  task automatic do_write(input logic [7:0] d, input bit cs_first, input bit lat);
    logic [7:0] old;
    old = code_m;
    @(negedge clk); data = d; cs_n = 1'b0;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk);
    if (cs_first) cs_n = 1'b1; else wr_n = 1'b1;
    data = ~d;
    in_m = d;
    if (!ld_n) model_code(d);
    @(negedge clk); cs_n = 1'b1; wr_n = 1'b1;
    @(negedge clk);
    if (lat) check("R8 old code after two edges", code, old);
    @(negedge clk);
    if (lat) check("R8 new code at third edge", code, d);
    repeat (3) @(negedge clk);
  endtask

  task automatic set_ld(input logic l);
    @(negedge clk); ld_n = l;
    if (!l) model_code(in_m);
    repeat (4) @(negedge clk);
  endtask

  task automatic settle(input string req);
    repeat (2) @(negedge clk);
    check(req, code, code_m);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset code", code, 8'h00);
        check("R6 reset pwrdn", {7'd0, pwrdn}, 8'h00);
        check("R6 reset out_en", {7'd0, out_en}, 8'h01);
        check("R7 reset upd", {7'd0, upd}, 8'h00);

        do_write(8'h5A, 1'b0, 1'b0);
        settle("R5 first write with load high keeps zero");
        set_ld(1'b0);
        settle("R3 load edge moves pending byte");

        do_write(8'h11, 1'b0, 1'b1);
        do_write(8'hFF, 1'b0, 1'b0); settle("R2 auto 0xFF");
        do_write(8'h00, 1'b0, 1'b0); settle("R2 auto 0x00");
        do_write(8'h80, 1'b0, 1'b0); settle("R2 auto 0x80");
        do_write(8'hC3, 1'b1, 1'b0); settle("R1 select rises first, late data change");

        // R9: strobe without select
        @(negedge clk); data = 8'h77; wr_n = 1'b0;
        repeat (4) @(negedge clk); wr_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R9 ignored strobe output", code, code_m);
        set_ld(1'b1); set_ld(1'b0);
        settle("R9 input register untouched");

        set_ld(1'b1);
        do_write(8'h3C, 1'b0, 1'b0); settle("R3 sync write holds");
        do_write(8'h96, 1'b0, 1'b0); settle("R3 second sync write holds");
        set_ld(1'b0); settle("R3 last write wins");

        @(negedge clk); clr_n = 1'b0;
        #1 check("R4 async clear", code, 8'h00);
        model_code(8'h00);
        repeat (3) @(negedge clk); clr_n = 1'b1;
        settle("R4 code register zeroed");

        set_ld(1'b1);
        do_write(8'hA5, 1'b0, 1'b0);
        @(negedge clk); clr_n = 1'b0; ld_n = 1'b0;
        repeat (4) @(negedge clk); clr_n = 1'b1;
        settle("R4 clear beats load edge");

        @(negedge clk); pd_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R6 pwrdn set", {7'd0, pwrdn}, 8'h01);
        check("R6 out_en cleared", {7'd0, out_en}, 8'h00);
        do_write(8'h42, 1'b0, 1'b0); settle("R6 writable in power-down");
        @(negedge clk); pd_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 pwrdn released", {7'd0, pwrdn}, 8'h00);
        check("R6 contents kept", code, 8'h42);

        do_write(8'h42, 1'b0, 1'b0); settle("R7 same value no strobe");
        repeat (4) @(negedge clk);
        check("R7 scoreboard drained", 8'(exp_q.size()), 8'h00);
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule